// File: doc/BRIEF.md
# Random Memory Tag Inserter

This block writes a pseudo-random 4-bit allocation tag into the upper byte of a 64-bit pointer. A 16-bit LFSR seed and a start tag are held in an internal state register. Every enabled operation steps the LFSR four times, and each step yields one bit of a 4-bit skip count. The chosen tag is found by walking forward from the start tag around the 16-entry tag ring. Each move advances one tag, and tags in the exclusion set are passed over. The chosen tag and the advanced seed then become the new state.

The exclusion set is the OR of two 16-bit masks. One comes with the operation and the other from a control setting. A request is a single-cycle `start` pulse. The block stays busy while it walks the ring, at one tag per cycle, and then raises `done` for one cycle with the rewritten pointer. A load port lets the surrounding logic, or a bench, preset the seed and the start tag.

Top module: `mem_tag_inserter`

## Requirements
- R1: After reset the state tag and state seed read zero, and `busy` and `done` are low.
- R2: With `busy` low, a `ld` pulse copies `ld_tag` and `ld_seed` into the state, visible at the next sample. `ld` has no effect while `busy` is high.
- R3: Each LFSR step forms a feedback bit as seed[5] ^ seed[3] ^ seed[2] ^ seed[0]. It then shifts the seed right by one and puts the feedback bit into seed[15]. An enabled operation runs four steps.
- R4: The feedback bit of step i (i = 0..3) becomes bit i of the 4-bit skip count, so the first step gives the least significant bit.
- R5: The exclusion set is `op_excl | ctl_excl`. Bit n set means tag n is excluded.
- R6: The tag starts at the state tag. For each unit of the skip count it moves forward by one modulo 16, and it keeps moving while it sits on an excluded tag.
- R7: When all 16 tags are excluded, the chosen tag is the state tag. The seed still advances.
- R8: A skip count of zero returns the state tag, even when that tag is excluded.
- R9: After an enabled operation the state holds the chosen tag and the seed as it stands after four steps.
- R10: `ptr_out` equals the captured `ptr_in`, except that bits [59:56] hold (tag − ptr_in[55]) mod 16.
- R11: With `tag_en` low at `start`, tag 0 is used, so bits [59:56] are (0 − ptr_in[55]) mod 16, and the state is left unchanged.
- R12: `done` is high for exactly one cycle per accepted request, and `busy` is low in that cycle. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when not busy |
| ptr_in | input | 64 | Pointer to be tagged |
| op_excl | input | 16 | Exclusion mask supplied with the request |
| ctl_excl | input | 16 | Exclusion mask from control setting |
| tag_en | input | 1 | Tag insertion enable; low forces tag 0 and freezes state |
| ld | input | 1 | Load state from ld_tag/ld_seed |
| ld_tag | input | 4 | Start tag value to load |
| ld_seed | input | 16 | Seed value to load |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| ptr_out | output | 64 | Tagged pointer, valid with done |
| st_tag | output | 4 | Current state start tag |
| st_seed | output | 16 | Current state seed |

## Verification
The assertions assume that `start` comes as short pulses and that the load port is quiet while a request is in flight. The bench pulses both inputs for one cycle and drives `ld` only while `busy` is low. The check that the search always ends relies on the walk never being entered with a full exclusion set. The stimulus gives full masks often, so the bypass path that guarantees this is exercised, alongside sparse, single-hole and empty masks. Random seeds and start tags cover every skip count.

// File: rtl/mem_tag_inserter.sv
module mem_tag_inserter #(
  parameter int PTR_W   = 64,
  parameter int TAG_W   = 4,
  parameter int TAG_POS = 56,
  parameter int SEED_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTR_W-1:0]  ptr_in,
  input  logic [(1<<TAG_W)-1:0] op_excl,
  input  logic [(1<<TAG_W)-1:0] ctl_excl,
  input  logic              tag_en,
  input  logic              ld,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [SEED_W-1:0] ld_seed,
  output logic              busy,
  output logic              done,
  output logic [PTR_W-1:0]  ptr_out,
  output logic [TAG_W-1:0]  st_tag,
  output logic [SEED_W-1:0] st_seed
);
  localparam int NTAGS = 1 << TAG_W;

  logic [PTR_W-1:0]  ptr_q;
  logic [NTAGS-1:0]  mask_q;
  logic [TAG_W-1:0]  tag_q, rem_q, off_q;
  logic [SEED_W-1:0] seed_n_q;
  logic              en_q;

  logic [SEED_W-1:0] seed_adv;
  logic [TAG_W-1:0]  off_c;
  always_comb begin
    logic fb;
    seed_adv = st_seed;
    off_c    = '0;
    for (int i = 0; i < TAG_W; i++) begin
      fb       = seed_adv[5] ^ seed_adv[3] ^ seed_adv[2] ^ seed_adv[0];
      seed_adv = {fb, seed_adv[SEED_W-1:1]};
      off_c[i] = fb;
    end
  end

  wire [NTAGS-1:0] mask_in = op_excl | ctl_excl;
  wire             all_ex  = &mask_in;
  wire [TAG_W-1:0] step_tag = tag_q + 1'b1;
  wire             step_ok  = !mask_q[step_tag];
  wire [TAG_W-1:0] field    = tag_q - {{(TAG_W-1){1'b0}}, ptr_q[TAG_POS-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      ptr_q    <= '0;
      ptr_out  <= '0;
      mask_q   <= '0;
      tag_q    <= '0;
      rem_q    <= '0;
      off_q    <= '0;
      seed_n_q <= '0;
      en_q     <= 1'b0;
      st_tag   <= '0;
      st_seed  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (ld) begin
          st_tag  <= ld_tag;
          st_seed <= ld_seed;
        end
        if (start) begin
          busy     <= 1'b1;
          ptr_q    <= ptr_in;
          mask_q   <= mask_in;
          en_q     <= tag_en;
          tag_q    <= tag_en ? st_tag : '0;
          rem_q    <= (tag_en && !all_ex) ? off_c : '0;
          off_q    <= off_c;
          seed_n_q <= seed_adv;
        end
      end else if (rem_q != '0) begin
        tag_q <= step_tag;
        if (step_ok) rem_q <= rem_q - 1'b1;
      end else begin
        busy    <= 1'b0;
        done    <= 1'b1;
        ptr_out <= {ptr_q[PTR_W-1:TAG_POS+TAG_W], field, ptr_q[TAG_POS-1:0]};
        if (en_q) begin
          st_tag  <= tag_q;
          st_seed <= seed_n_q;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R12
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(ptr_q) && $stable(mask_q)); // R12
  AST_WALK_HAS_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rem_q != '0 |-> !(&mask_q)); // R7
  AST_TAG_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
    done && en_q && !(&mask_q) && off_q != '0 |-> !mask_q[st_tag]); // R6
  AST_FIELD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done && en_q |-> ptr_out[TAG_POS+TAG_W-1:TAG_POS] + {{(TAG_W-1){1'b0}}, ptr_out[TAG_POS-1]} == st_tag); // R10
  AST_OFF_STATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !en_q |=> $stable(st_tag) && $stable(st_seed)); // R11
endmodule

// File: tb/tb_mem_tag_inserter.sv
module tb_mem_tag_inserter;
  logic        clk = 0, rst_n = 0, start = 0, tag_en = 0, ld = 0;
  logic [63:0] ptr_in = '0;
  logic [15:0] op_excl = '0, ctl_excl = '0, ld_seed = '0;
  logic [3:0]  ld_tag = '0;
  logic        busy, done;
  logic [63:0] ptr_out;
  logic [3:0]  st_tag;
  logic [15:0] st_seed;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mem_tag_inserter dut (.clk, .rst_n, .start, .ptr_in, .op_excl, .ctl_excl,
    .tag_en, .ld, .ld_tag, .ld_seed, .busy, .done, .ptr_out, .st_tag, .st_seed);

  function automatic logic [19:0] m_lfsr(input logic [15:0] s);
    logic [3:0] off; logic fb;
    for (int i = 0; i < 4; i++) begin
      fb = s[5] ^ s[3] ^ s[2] ^ s[0];
      s = {fb, s[15:1]};
      off[i] = fb;
    end
    return {off, s};
  endfunction

  function automatic logic [3:0] m_pick(input logic [3:0] t, input logic [3:0] off, input logic [15:0] m);
    if (m == 16'hFFFF) return t;
    for (int i = 0; i < off; i++) begin
      t = t + 1;
      while (m[t]) t = t + 1;
    end
    return t;
  endfunction

  function automatic logic [63:0] m_ptr(input logic [63:0] p, input logic [3:0] t);
    p[59:56] = t - {3'b0, p[55]};
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] t, input logic [15:0] s);
    @(negedge clk); ld = 1; ld_tag = t; ld_seed = s;
    @(negedge clk); ld = 0;
  endtask

  task automatic run_op(input logic [63:0] p, input logic [15:0] om, input logic [15:0] cm,
                        input logic en, input logic poke, input string req);
    logic [19:0] lf; logic [3:0] t0, tag; logic [15:0] s0; int n;
    t0 = st_tag; s0 = st_seed;
    lf = m_lfsr(s0);
    tag = en ? m_pick(t0, lf[19:16], om | cm) : 4'h0;
    @(negedge clk); start = 1; ptr_in = p; op_excl = om; ctl_excl = cm; tag_en = en;
    @(negedge clk); start = 0;
    if (poke) begin
      start = 1; ptr_in = ~p; op_excl = 16'h0; tag_en = ~en;
      ld = 1; ld_tag = ~t0; ld_seed = ~s0;
      @(negedge clk); start = 0; ld = 0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk({req, " done seen"}, done, 1'b1);
    chk({req, " R10 ptr_out"}, ptr_out, m_ptr(p, tag));
    chk({req, " R9 st_tag"}, st_tag, en ? tag : t0);
    chk({req, " R3 st_seed"}, st_seed, en ? lf[15:0] : s0);
    @(negedge clk);
    chk({req, " R12 single done"}, {busy, done}, 2'b00);
  endtask

  initial begin
    #(8ns * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] m;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", {busy, done, st_tag, st_seed}, 22'h0);

    load(4'h9, 16'hACE1);
    chk("R2 load", {st_tag, st_seed}, {4'h9, 16'hACE1});

    // R4 R6: seed 0x0001 gives step-0 feedback 1 then zeros -> offset 1
    load(4'h3, 16'h0001);
    run_op(64'h0080_1234_5678_9ABC, 16'h0010, 16'h0000, 1'b1, 1'b0, "R4 offset one");
    chk("R6 skip excluded", ptr_out[59:56], 4'h5 - 4'h1);

    // R5: operand and control masks combine
    load(4'h0, 16'h0001);
    run_op(64'h1111_2222_3333_4444, 16'h0002, 16'h0004, 1'b1, 1'b0, "R5 mask or");
    chk("R5 tag 3", st_tag, 4'h3);

    // R7: all excluded
    load(4'h7, 16'hBEEF);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 16'hFF00, 16'h00FF, 1'b1, 1'b0, "R7 all excluded");
    chk("R7 keeps start", st_tag, 4'h7);

    // R8: offset 0 with excluded start tag
    load(4'hA, 16'h0000);
    run_op(64'h0012_0000_0000_0000, 16'h0400, 16'h0000, 1'b1, 1'b0, "R8 zero offset");
    chk("R8 excluded start kept", st_tag, 4'hA);

    // R11: disabled
    load(4'h5, 16'h1357);
    run_op(64'h0F80_0000_0000_0001, 16'h0000, 16'h0000, 1'b0, 1'b0, "R11 disabled");
    chk("R11 field", ptr_out[59:56], 4'hF);

    // R12 and R2: start and ld during busy are ignored
    load(4'h2, 16'h8001);
    run_op(64'h0123_4567_89AB_CDEF, 16'h0F0F, 16'h0000, 1'b1, 1'b1, "R12 busy start");

    for (int k = 0; k < 300; k++) begin
      load($urandom, $urandom);
      case ($urandom % 5)
        0: m = 16'h0;
        1: m = $urandom & $urandom & $urandom;
        2: m = $urandom;
        3: m = ~(16'h1 << ($urandom % 16));
        default: m = 16'hFFFF;
      endcase
      run_op({$urandom, $urandom}, m & $urandom, m, ($urandom % 4) != 0,
             ($urandom % 8) == 0, "random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule